// File: doc/BRIEF.md
# Pseudo-Associative Cache Lookup

This block is a single-word-line cache controller that sits between a processor-side request port and a slower lower-level memory. Its storage is organised as a direct-mapped array. Every address also owns a second, backup slot in the other half of the array. A request first checks its home slot. If that misses, the controller checks the backup slot one cycle later. Only when both checks fail does it go to memory. The result is three latency classes: a fast hit, a slower pseudo-hit, and a full miss whose latency depends on memory.

Blocks are kept close to the front of their own slot pair. A pseudo-hit exchanges the two slots, so the block that was just used becomes the fast one. A refill puts the new block in the home slot and pushes the previous occupant into the backup slot. Writes are passed straight through to memory. A write updates the cached copy only when the block is already present.

Top module: `pseudo_assoc_cache`

## Requirements
- R1: After reset `ready_o`=1, `rsp_valid_o`=0 and `mem_req_o`=0. Every line is invalid, so the first read of any address goes to memory.
- R2: The home slot index is `addr_i[IDX_W-1:0]`. A read whose block is valid in its home slot raises `rsp_valid_o` in the cycle after acceptance, with the stored word on `rdata_o`.
- R3: The backup slot index is the home index with its top bit inverted. A read that misses at home and matches in the backup slot responds two cycles after acceptance.
- R4: A read that misses in both slots raises `mem_req_o` with `mem_we_o`=0 and `mem_addr_o` equal to the request address. It responds in the cycle after the cycle in which `mem_ack_i` is high, returning `mem_rdata_i`.
- R5: Each stored tag is `addr[ADDR_W-1:IDX_W-1]`, which includes the top index bit. A block that sits in a slot as a backup is never taken for a request whose home is that slot.
- R6: On a pseudo-hit the home and backup slot contents are exchanged. The next access to that block is a one-cycle hit, and the displaced block becomes a pseudo-hit.
- R7: On a refill, a valid block in the home slot moves to the backup slot and the fetched block fills the home slot. If the home slot was invalid, the backup slot is left untouched.
- R8: Every write issues a memory write with the request address and data. A write that hits at home updates the slot in place and responds the cycle after the ack. A pseudo-hit write exchanges the two slots, updates the moved block, and responds the cycle after the ack. A write miss allocates nothing.
- R9: While a request is in progress `ready_o`=0 and new requests are ignored. `mem_req_o`, `mem_addr_o`, `mem_we_o` and `mem_wdata_o` hold steady until `mem_ack_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| req_i | input | 1 | request strobe, taken when ready_o is high |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | word address |
| wdata_i | input | DATA_W | write data |
| ready_o | output | 1 | controller idle and accepting |
| rsp_valid_o | output | 1 | one-cycle completion pulse |
| rdata_o | output | DATA_W | read data, valid with rsp_valid_o on reads |
| mem_req_o | output | 1 | memory request, held until ack |
| mem_we_o | output | 1 | memory write enable |
| mem_addr_o | output | ADDR_W | memory word address |
| mem_wdata_o | output | DATA_W | memory write data |
| mem_ack_i | input | 1 | memory completion, one cycle |
| mem_rdata_i | input | DATA_W | memory read data, valid with mem_ack_i |

## Verification
Directed sequences reuse one slot pair so that a single block passes through every latency class: a cold miss, a home hit, eviction to the backup slot, a pseudo-hit with exchange, and a home hit again. Two addresses differ only in the top index bit and share the upper bits; these expose a tag that drops that bit, because a false hit would change the latency class. A refill into an empty home slot followed by a re-read of the backup block separates "move only valid occupants" from "always move". A random mix of reads and writes over a small address window, with varying memory delay, checks latency, data and memory traffic against a bench model of the slot pairs. A request raised while the controller is busy confirms that nothing reaches memory or the array.

// File: rtl/pca_pkg.sv
package pca_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ALT  = 2'd1,
    ST_MEM  = 2'd2,
    ST_WR   = 2'd3
  } pca_state_e;
endpackage

// File: rtl/pca_line_store.sv
module pca_line_store #(
  parameter int LINES  = 16,
  parameter int TAG_W  = 13,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  p_idx_i,
  input  logic [IDX_W-1:0]  a_idx_i,
  output logic              p_valid_o,
  output logic [TAG_W-1:0]  p_tag_o,
  output logic [DATA_W-1:0] p_data_o,
  output logic              a_valid_o,
  output logic [TAG_W-1:0]  a_tag_o,
  output logic [DATA_W-1:0] a_data_o,
  input  logic              w0_en_i,
  input  logic [IDX_W-1:0]  w0_idx_i,
  input  logic              w0_valid_i,
  input  logic [TAG_W-1:0]  w0_tag_i,
  input  logic [DATA_W-1:0] w0_data_i,
  input  logic              w1_en_i,
  input  logic [IDX_W-1:0]  w1_idx_i,
  input  logic              w1_valid_i,
  input  logic [TAG_W-1:0]  w1_tag_i,
  input  logic [DATA_W-1:0] w1_data_i
);
  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else begin
      if (w0_en_i) valid_q[w0_idx_i] <= w0_valid_i;
      if (w1_en_i) valid_q[w1_idx_i] <= w1_valid_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (w0_en_i) begin
      tag_q[w0_idx_i]  <= w0_tag_i;
      data_q[w0_idx_i] <= w0_data_i;
    end
    if (w1_en_i) begin
      tag_q[w1_idx_i]  <= w1_tag_i;
      data_q[w1_idx_i] <= w1_data_i;
    end
  end

  assign p_valid_o = valid_q[p_idx_i];
  assign p_tag_o   = tag_q[p_idx_i];
  assign p_data_o  = data_q[p_idx_i];
  assign a_valid_o = valid_q[a_idx_i];
  assign a_tag_o   = tag_q[a_idx_i];
  assign a_data_o  = data_q[a_idx_i];

  // R6
  dual_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w0_en_i && w1_en_i) |-> (w0_idx_i != w1_idx_i));
endmodule

// File: rtl/pca_probe.sv
module pca_probe #(
  parameter int TAG_W = 13
) (
  input  logic             valid_i,
  input  logic [TAG_W-1:0] stored_tag_i,
  input  logic [TAG_W-1:0] req_tag_i,
  output logic             match_o
);
  assign match_o = valid_i && (stored_tag_i == req_tag_i);
endmodule

// File: rtl/pca_ctrl.sv
module pca_ctrl
  import pca_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [IDX_W-1:0]  p_idx_o,
  output logic [IDX_W-1:0]  a_idx_o,
  output logic [TAG_W-1:0]  tag_o,
  input  logic              p_hit_i,
  input  logic              a_hit_i,
  input  logic              p_valid_i,
  input  logic [TAG_W-1:0]  p_tag_i,
  input  logic [DATA_W-1:0] p_data_i,
  input  logic              a_valid_i,
  input  logic [TAG_W-1:0]  a_tag_i,
  input  logic [DATA_W-1:0] a_data_i,
  output logic              w0_en_o,
  output logic [IDX_W-1:0]  w0_idx_o,
  output logic              w0_valid_o,
  output logic [TAG_W-1:0]  w0_tag_o,
  output logic [DATA_W-1:0] w0_data_o,
  output logic              w1_en_o,
  output logic [IDX_W-1:0]  w1_idx_o,
  output logic              w1_valid_o,
  output logic [TAG_W-1:0]  w1_tag_o,
  output logic [DATA_W-1:0] w1_data_o
);
  localparam logic [IDX_W-1:0] HALF_MASK = {1'b1, {(IDX_W-1){1'b0}}};

  pca_state_e        st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_d;
  logic              we_q, rsp_d, accept;
  logic [ADDR_W-1:0] look_addr;

  assign ready_o   = (st_q == ST_IDLE);
  assign accept    = ready_o && req_i;
  // idle looks at the live request, later states at the captured one
  assign look_addr = ready_o ? addr_i : addr_q;
  assign p_idx_o   = look_addr[IDX_W-1:0];
  assign a_idx_o   = look_addr[IDX_W-1:0] ^ HALF_MASK;
  assign tag_o     = look_addr[ADDR_W-1:IDX_W-1];

  assign mem_req_o   = (st_q == ST_MEM) || (st_q == ST_WR);
  assign mem_we_o    = (st_q == ST_WR);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;

  always_comb begin
    st_d       = st_q;
    rsp_d      = 1'b0;
    rdata_d    = rdata_o;
    w0_en_o    = 1'b0;
    w0_idx_o   = p_idx_o;
    w0_valid_o = 1'b1;
    w0_tag_o   = tag_o;
    w0_data_o  = wdata_i;
    w1_en_o    = 1'b0;
    w1_idx_o   = a_idx_o;
    w1_valid_o = p_valid_i;
    w1_tag_o   = p_tag_i;
    w1_data_o  = p_data_i;
    unique case (st_q)
      ST_IDLE: begin
        if (req_i) begin
          if (p_hit_i) begin
            if (we_i) begin
              w0_en_o = 1'b1;
              st_d    = ST_WR;
            end else begin
              rsp_d   = 1'b1;
              rdata_d = p_data_i;
            end
          end else begin
            st_d = ST_ALT;
          end
        end
      end
      ST_ALT: begin
        if (a_hit_i) begin
          // exchange the pair; the found block moves home
          w0_en_o    = 1'b1;
          w0_valid_o = a_valid_i;
          w0_tag_o   = a_tag_i;
          w0_data_o  = we_q ? wdata_q : a_data_i;
          w1_en_o    = 1'b1;
          if (we_q) begin
            st_d = ST_WR;
          end else begin
            rsp_d   = 1'b1;
            rdata_d = a_data_i;
            st_d    = ST_IDLE;
          end
        end else begin
          st_d = we_q ? ST_WR : ST_MEM;
        end
      end
      ST_MEM: begin
        if (mem_ack_i) begin
          w0_en_o   = 1'b1;
          w0_data_o = mem_rdata_i;
          w1_en_o   = p_valid_i;
          rsp_d     = 1'b1;
          rdata_d   = mem_rdata_i;
          st_d      = ST_IDLE;
        end
      end
      ST_WR: begin
        if (mem_ack_i) begin
          rsp_d = 1'b1;
          st_d  = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      addr_q      <= '0;
      wdata_q     <= '0;
      we_q        <= 1'b0;
      rsp_valid_o <= 1'b0;
      rdata_o     <= '0;
    end else begin
      st_q        <= st_d;
      rsp_valid_o <= rsp_d;
      rdata_o     <= rdata_d;
      if (accept) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        we_q    <= we_i;
      end
    end
  end

  // R2
  hit_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && p_hit_i && !we_i) |=> rsp_valid_o);
  // R3
  pseudo_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ALT && a_hit_i && !we_q) |=> rsp_valid_o);
  // R4
  fetch_after_probe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mem_req_o) && !mem_we_o) |-> $past(st_q == ST_ALT && !a_hit_i));
  // R4
  miss_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i) |=> rsp_valid_o);
  // R9
  hold_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
  // R9
  busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> ready_o);
endmodule

// File: rtl/pseudo_assoc_cache.sv
module pseudo_assoc_cache #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic [IDX_W-1:0]  p_idx, a_idx, w0_idx, w1_idx;
  logic [TAG_W-1:0]  req_tag, p_tag, a_tag, w0_tag, w1_tag;
  logic [DATA_W-1:0] p_data, a_data, w0_data, w1_data;
  logic              p_valid, a_valid, p_hit, a_hit;
  logic              w0_en, w0_valid, w1_en, w1_valid;

  pca_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_store (
    .clk_i, .rst_ni,
    .p_idx_i(p_idx), .a_idx_i(a_idx),
    .p_valid_o(p_valid), .p_tag_o(p_tag), .p_data_o(p_data),
    .a_valid_o(a_valid), .a_tag_o(a_tag), .a_data_o(a_data),
    .w0_en_i(w0_en), .w0_idx_i(w0_idx), .w0_valid_i(w0_valid), .w0_tag_i(w0_tag), .w0_data_i(w0_data),
    .w1_en_i(w1_en), .w1_idx_i(w1_idx), .w1_valid_i(w1_valid), .w1_tag_i(w1_tag), .w1_data_i(w1_data)
  );

  pca_probe #(.TAG_W(TAG_W)) i_probe_home (
    .valid_i(p_valid), .stored_tag_i(p_tag), .req_tag_i(req_tag), .match_o(p_hit)
  );

  pca_probe #(.TAG_W(TAG_W)) i_probe_backup (
    .valid_i(a_valid), .stored_tag_i(a_tag), .req_tag_i(req_tag), .match_o(a_hit)
  );

  pca_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) i_ctrl (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .ready_o, .rsp_valid_o, .rdata_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i,
    .p_idx_o(p_idx), .a_idx_o(a_idx), .tag_o(req_tag),
    .p_hit_i(p_hit), .a_hit_i(a_hit),
    .p_valid_i(p_valid), .p_tag_i(p_tag), .p_data_i(p_data),
    .a_valid_i(a_valid), .a_tag_i(a_tag), .a_data_i(a_data),
    .w0_en_o(w0_en), .w0_idx_o(w0_idx), .w0_valid_o(w0_valid), .w0_tag_o(w0_tag), .w0_data_o(w0_data),
    .w1_en_o(w1_en), .w1_idx_o(w1_idx), .w1_valid_o(w1_valid), .w1_tag_o(w1_tag), .w1_data_o(w1_data)
  );
endmodule

// File: tb/test_pseudo_assoc_cache.sv
module test_pseudo_assoc_cache;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int LINES  = 16;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_i = 1'b0, we_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic              ready_o, rsp_valid_o, mem_req_o, mem_we_o;
  logic [DATA_W-1:0] rdata_o, mem_wdata_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic              mem_ack_i = 1'b0;
  logic [DATA_W-1:0] mem_rdata_i = '0;

  pseudo_assoc_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) i_pseudo_assoc_cache (
    .clk_i(clk), .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .ready_o, .rsp_valid_o, .rdata_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i
  );

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  // memory responder state
  logic [DATA_W-1:0] bmem [256];
  int resp_delay = 0, wait_cnt = 0, txn_cnt = 0, unstable = 0;
  logic [ADDR_W-1:0] first_addr, last_addr;
  logic              last_we;
  logic [DATA_W-1:0] last_wdata;

  // bench model of the slots
  bit          mv [LINES];
  int unsigned mt [LINES];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int home(int unsigned a); return a % LINES; endfunction
  function automatic int backup(int unsigned a); return (a % LINES) ^ (LINES/2); endfunction
  function automatic int unsigned tagof(int unsigned a); return a / (LINES/2); endfunction

  // 0 = home hit, 1 = pseudo-hit, 2 = miss
  function automatic int predict(int unsigned a);
    if (mv[home(a)] && mt[home(a)] == tagof(a)) return 0;
    if (mv[backup(a)] && mt[backup(a)] == tagof(a)) return 1;
    return 2;
  endfunction

  task automatic model_update(int unsigned a, bit w);
    int cls = predict(a);
    int p = home(a);
    int b = backup(a);
    bit tv; int unsigned tt;
    if (cls == 1) begin
      tv = mv[p]; tt = mt[p];
      mv[p] = mv[b]; mt[p] = mt[b];
      mv[b] = tv; mt[b] = tt;
    end else if (cls == 2 && !w) begin
      if (mv[p]) begin mv[b] = 1'b1; mt[b] = mt[p]; end
      mv[p] = 1'b1; mt[p] = tagof(a);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = 32'hC0DE_0000 | i;
    for (int i = 0; i < LINES; i++) begin mv[i] = 1'b0; mt[i] = 0; end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack_i) begin
        mem_ack_i = 1'b0;
        wait_cnt  = 0;
      end else if (mem_req_o) begin
        if (wait_cnt == 0) first_addr = mem_addr_o;
        else if (mem_addr_o != first_addr) unstable++;
        if (wait_cnt >= resp_delay) begin
          mem_ack_i   = 1'b1;
          mem_rdata_i = bmem[mem_addr_o[7:0]];
          if (mem_we_o) bmem[mem_addr_o[7:0]] = mem_wdata_o;
          last_addr  = mem_addr_o;
          last_we    = mem_we_o;
          last_wdata = mem_wdata_o;
          txn_cnt++;
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  // one access: check latency, data and memory traffic against the model
  task automatic access(int unsigned a, bit w, logic [DATA_W-1:0] wd, int d,
                        string req, bit noise = 1'b0, int unsigned noise_a = 0);
    int cls = predict(a);
    int exp_lat;
    int lat = 0;
    int txn0 = txn_cnt;
    logic [DATA_W-1:0] exp_data;
    resp_delay = d;
    @(negedge clk);
    chk(ready_o == 1'b1, "R9", "ready before request", ready_o, 1);
    exp_data = bmem[a[7:0]];
    req_i = 1'b1; we_i = w; addr_i = ADDR_W'(a); wdata_i = wd;
    @(posedge clk);
    forever begin
      @(negedge clk);
      lat++;
      if (lat == 1) begin
        if (noise) begin
          chk(ready_o == 1'b0, "R9", "ready while busy", ready_o, 0);
          we_i = 1'b1; addr_i = ADDR_W'(noise_a); wdata_i = 32'hDEAD_BEEF;
        end else begin
          req_i = 1'b0;
        end
      end
      if (rsp_valid_o || lat > 60) break;
    end
    req_i = 1'b0;
    if (w) exp_lat = (cls == 0) ? 2 + d : 3 + d;
    else   exp_lat = (cls == 0) ? 1 : (cls == 1) ? 2 : 3 + d;
    chk(lat == exp_lat, req, $sformatf("latency addr %0h class %0d", a, cls), lat, exp_lat);
    if (!w) chk(rdata_o == exp_data, req, $sformatf("read data addr %0h", a), rdata_o, exp_data);
    if (w || cls == 2) begin
      chk(txn_cnt == txn0 + 1, req, "memory transaction count", txn_cnt - txn0, 1);
      chk(last_addr == ADDR_W'(a) && last_we == w, req, "memory address/we",
          {last_we, last_addr}, {w, ADDR_W'(a)});
      if (w) chk(last_wdata == wd, "R8", "memory write data", last_wdata, wd);
    end else begin
      chk(txn_cnt == txn0, req, "no memory traffic on hit", txn_cnt - txn0, 0);
    end
    model_update(a, w);
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd4711);
    repeat (2) @(negedge clk);
    // R1
    chk(ready_o == 1'b1 && rsp_valid_o == 1'b0 && mem_req_o == 1'b0, "R1", "reset outputs",
        {ready_o, rsp_valid_o, mem_req_o}, 3'b100);
    @(negedge clk) rst_ni = 1'b1;
    // cold read: R1 (invalid lines), R4 miss
    access(32'h05, 1'b0, '0, 2, "R1");
    access(32'h05, 1'b0, '0, 0, "R2");
    access(32'h15, 1'b0, '0, 1, "R7");   // 0x05 moves to slot 13
    access(32'h05, 1'b0, '0, 0, "R3");   // pseudo-hit, exchange
    access(32'h05, 1'b0, '0, 0, "R6");   // now a home hit
    access(32'h15, 1'b0, '0, 0, "R6");   // displaced block is pseudo
    // 0x05 is in slot 13 as backup; 0x0D has home 13 and shares upper bits
    access(32'h0D, 1'b0, '0, 1, "R5");
    // refill into empty home keeps backup
    access(32'h02, 1'b0, '0, 0, "R4");
    access(32'h0A, 1'b0, '0, 3, "R7");
    access(32'h02, 1'b0, '0, 0, "R7");
    // writes
    access(32'h0A, 1'b1, 32'h1111_0001, 1, "R8");
    access(32'h0A, 1'b0, '0, 0, "R8");
    access(32'h0D, 1'b1, 32'h2222_0002, 0, "R8");  // check class via model
    access(32'h30, 1'b1, 32'h3333_0003, 2, "R8");  // write miss
    access(32'h30, 1'b0, '0, 1, "R8");             // must miss: no allocate
    // request while busy is ignored
    access(32'h2F, 1'b0, '0, 3, "R9", 1'b1, 32'h07);
    access(32'h07, 1'b0, '0, 0, "R9");
    chk(bmem[8'h07] == (32'hC0DE_0000 | 32'h07), "R9", "ignored write reached memory",
        bmem[8'h07], 32'hC0DE_0007);
    // random mix
    for (int n = 0; n < 400; n++) begin
      int unsigned a = $urandom % 64;
      bit w = ($urandom % 10) < 3;
      access(a, w, $urandom, int'($urandom % 4), w ? "R8" : "R4");
    end
    chk(unstable == 0, "R9", "memory request changed before ack", unstable, 0);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule